// File: doc/BRIEF.md
# Keyed Non-Stoppable Watchdog Timer

This block is a watchdog that cannot be switched off. It counts on a dedicated slow clock that comes from a free-running on-chip oscillator. That count clock is fixed and cannot be replaced by another source. When reset is released, the block begins counting at its longest timeout. If software fails to refresh it in time, the block raises a single-cycle reset request on the bus clock. The count goes on while the processor is halted, so a halted system is recovered by that reset request.

Software sees two byte-wide registers on a simple write/read strobe interface:

- **Timing-control register.** Holds a 3-bit timeout selector. Selector value n gives a timeout of 2^(BASE_EXP+n) slow-clock cycles, with BASE_EXP = 11 by default. Bits 4:3 report the fixed count-source choice and cannot be changed.
- **Restart register.** The only accepted value is the key byte 0xAC. Writing the key restarts the count from zero. Writing any other byte is treated as runaway code, and the reset request is raised at once.

Any write to the timing-control register also restarts the count.

Bus events cross into the slow domain through a toggle handshake. The crossing carries a stable copy of the selector. Events that arrive while a crossing is still in flight are merged into one. An overflow returns to the bus domain through a two-flop synchroniser with edge detection. The incoming pulse is one slow-clock period wide, which stretches it across many bus cycles. After any reset request, the selector returns to its maximum and the count restarts from zero.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `rst_req` is low and reading address 0 (timing control) returns 0x1F: selector 3'b111 in bits 2:0, and bits 4:3 read as 2'b11.
- R2: Without any bus write after reset release, `rst_req` pulses once 2^(BASE_EXP+7) slow-clock cycles after release, plus the synchroniser latency.
- R3: Writing selector n to bits 2:0 of address 0 sets the timeout to 2^(BASE_EXP+n) slow-clock cycles, counted from the write.
- R4: Bits 4:3 of address 0 always read 2'b11 and bits 7:5 always read 0, whatever value was written to them.
- R5: Writing 0xAC to address 1 (restart) sets the count back to zero, and a new full timeout begins.
- R6: Any write to address 0 sets the count back to zero, and a new full timeout begins.
- R7: Writing any byte other than 0xAC to address 1 makes `rst_req` high in the bus cycle after the write.
- R8: Each reset request appears on `rst_req` as a pulse exactly one bus-clock cycle long.
- R9: After a reset request, the selector reads back 3'b111 and the count restarts from zero at the maximum timeout.
- R10: Reading address 1 returns 0x00.
- R11: No register value stops counting. A selector written together with set upper bits still times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| lclk | input | 1 | Low-speed oscillator clock used for counting |
| lrst_n | input | 1 | Synchronous active-low reset, slow domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 1 | Register select: 0 timing control, 1 restart |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The reset request that follows a bad key is due one bus cycle after the write. It is sampled at the following falling edge, and the falling edge after that must show it low again.

A timeout is due 2^(BASE_EXP+n) slow periods after a restart event, plus the crossing latency. That latency is one launch cycle, three slow edges into the counter, and four bus registers back to the output. Slow-clock phase adds up to one slow period of uncertainty. Each timeout is therefore checked against a window about three slow periods wide, which is narrow enough to reject a halved or doubled period.

Before every timed scenario, the bench idles long enough for any earlier crossing to finish, so that a merged event cannot shift the measurement.

// File: rtl/keyed_wdt_pkg.sv
// Package: shared constants for the keyed watchdog.
// Assumes a one-bit register address and byte-wide data.
package keyed_wdt_pkg;
    localparam logic       ADDR_MODE  = 1'b0;   // timing-control register
    localparam logic       ADDR_CLEAR = 1'b1;   // restart register
    localparam logic [7:0] CLEAR_KEY  = 8'hAC;  // only accepted restart byte
    localparam logic [1:0] SRC_FIXED  = 2'b11;  // read-only count-source code
    localparam int         SRC_LSB    = 3;      // position of the source field
endpackage

// File: rtl/wdt_sync2.sv
// Two-flop synchroniser for quasi-static or slowly toggling signals.
// Assumes each input bit changes at most once per several destination cycles.
module wdt_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Sample the asynchronous input through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/wdt_bus_regs.sv
// Bus-domain register file of the watchdog.
// It holds the timeout selector and decodes writes and the restart key.
// It merges restart events into a toggle request that is launched only
// when the previous one has been acknowledged, and it registers the
// reset request.
// Assumes SEL_W <= 3 and one write per strobe cycle.
module wdt_bus_regs
    import keyed_wdt_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [7:0]       wdata,
    input  logic             ovf_evt,
    input  logic             ack_s,
    output logic [7:0]       rd_data,
    output logic             rst_req,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] sel_hold,
    output logic             req_q,
    output logic             pend_q
);
    localparam logic [SEL_W-1:0] SEL_MAX = '1;

    logic mode_wr;
    logic clr_wr;
    logic key_ok;
    logic key_bad;
    logic rst_evt;
    logic any_evt;
    logic launch;

    // Decode bus writes into restart and reset events.
    always_comb begin
        mode_wr = wr_en && (addr == ADDR_MODE);
        clr_wr  = wr_en && (addr == ADDR_CLEAR);
        key_ok  = clr_wr && (wdata == CLEAR_KEY);
        key_bad = clr_wr && (wdata != CLEAR_KEY);
        rst_evt = ovf_evt || key_bad;
        any_evt = mode_wr || key_ok || rst_evt;
        launch  = pend_q && (req_q == ack_s);
    end

    // Selector: forced to maximum on reset request, otherwise loaded on mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_MAX;
        end else if (rst_evt) begin
            sel_q <= SEL_MAX;
        end else if (mode_wr) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Register the reset request, one cycle per event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= rst_evt;
        end
    end

    // Pending flag: an event waits here until the crossing is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= any_evt || (pend_q && !launch);
        end
    end

    // Launch a restart: flip the request and freeze the selector copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            sel_hold <= SEL_MAX;
        end else if (launch) begin
            req_q    <= ~req_q;
            sel_hold <= sel_q;
        end
    end

    // Read mux: fixed source code and selector, restart register reads zero.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_MODE) begin
            rd_data[SRC_LSB+1:SRC_LSB] = SRC_FIXED;
            rd_data[SEL_W-1:0]         = sel_q;
        end
    end
endmodule

// File: rtl/wdt_lsc_counter.sv
// Slow-domain timeout counter.
// It restarts from zero, with a freshly captured selector, whenever the
// synchronised request differs from the last one seen, and it raises an
// overflow level for one slow cycle at the terminal count.
// Assumes sel_in is stable while a request is outstanding and BASE_EXP >= 1.
module wdt_lsc_counter #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 11,
    parameter int CNT_W    = 18
) (
    input  logic             lclk,
    input  logic             lrst_n,
    input  logic             req_s,
    input  logic [SEL_W-1:0] sel_in,
    output logic             ack_q,
    output logic             ovf_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_last
);
    localparam logic [SEL_W-1:0] SEL_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [SEL_W-1:0] sel_l;
    logic             restart;

    // Terminal count for the active selector; the top step wraps to all ones.
    always_comb begin
        cnt_last = (ONE << (BASE_EXP + int'(sel_l))) - ONE;
        restart  = (req_s != ack_q);
    end

    // Count, restart on request, flag overflow and wrap.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            cnt_q <= '0;
            sel_l <= SEL_MAX;
            ovf_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= req_s;
            if (restart) begin
                cnt_q <= '0;
                sel_l <= sel_in;
                ovf_q <= 1'b0;
            end else if (cnt_q == cnt_last) begin
                cnt_q <= '0;
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + ONE;
                ovf_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdt_pulse_rx.sv
// Brings the slow-domain overflow level into the bus domain.
// Two flops resynchronise it, and a rising-edge detector then turns it
// into a single bus-cycle pulse.
// Assumes the level lasts at least one slow period and the bus clock is faster.
module wdt_pulse_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic lvl_s;
    logic lvl_d;

    wdt_sync2 #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lvl),
        .q     (lvl_s)
    );

    // Detect the rising edge of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= 1'b0;
            pulse <= 1'b0;
        end else begin
            lvl_d <= lvl_s;
            pulse <= lvl_s & ~lvl_d;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
// Top of the keyed watchdog.
// The bus-side registers feed a toggle handshake into the slow counter,
// and the overflow travels back through a synchroniser to the reset request.
// Assumes both resets are asserted together and lclk is slower than clk.
module keyed_wdt #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lclk,
    input  logic       lrst_n,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_data,
    output logic       rst_req
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_hold;
    logic             req_q;
    logic             pend_q;
    logic             ack_s;
    logic             ovf_evt;
    logic             req_l;
    logic             ack_l;
    logic             ovf_l;
    logic [CNT_W-1:0] lcnt;
    logic [CNT_W-1:0] lcnt_last;

    wdt_bus_regs #(.SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .ovf_evt  (ovf_evt),
        .ack_s    (ack_s),
        .rd_data  (rd_data),
        .rst_req  (rst_req),
        .sel_q    (sel_q),
        .sel_hold (sel_hold),
        .req_q    (req_q),
        .pend_q   (pend_q)
    );

    wdt_sync2 #(.W(1)) u_req_sync (
        .clk   (lclk),
        .rst_n (lrst_n),
        .d     (req_q),
        .q     (req_l)
    );

    wdt_lsc_counter #(
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .lclk     (lclk),
        .lrst_n   (lrst_n),
        .req_s    (req_l),
        .sel_in   (sel_hold),
        .ack_q    (ack_l),
        .ovf_q    (ovf_l),
        .cnt_q    (lcnt),
        .cnt_last (lcnt_last)
    );

    wdt_sync2 #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_l),
        .q     (ack_s)
    );

    wdt_pulse_rx u_ovf_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ovf_l),
        .pulse (ovf_evt)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
// Checker for the keyed watchdog, bound to every keyed_wdt instance.
// It watches the bus decode, the handshake protocol and the slow counter.
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lclk,
    input logic             lrst_n,
    input logic             wr_en,
    input logic             addr,
    input logic [7:0]       wdata,
    input logic [7:0]       rd_data,
    input logic             rst_req,
    input logic [SEL_W-1:0] sel_q,
    input logic             pend_q,
    input logic             req_q,
    input logic             ack_s,
    input logic             ovf_l,
    input logic [CNT_W-1:0] lcnt,
    input logic [CNT_W-1:0] lcnt_last
);
    localparam logic [SEL_W-1:0] SEL_MAX = '1;

    AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CLEAR && wdata != CLEAR_KEY) |=> rst_req); // R7
    AST_RESET_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (sel_q == SEL_MAX)); // R9
    AST_MODE_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_MODE) |=> pend_q); // R6
    AST_KEY_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CLEAR && wdata == CLEAR_KEY) |=> pend_q); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != ack_s) |=> $stable(req_q)); // R6
    AST_CNT_BOUND: assert property (@(posedge lclk) disable iff (!lrst_n)
        lcnt <= lcnt_last); // R3
    AST_OVF_SINGLE: assert property (@(posedge lclk) disable iff (!lrst_n)
        ovf_l |=> !ovf_l); // R2

    // Read-back checks on the register image.
    always @(posedge clk) begin
        if (rst_n && addr == ADDR_MODE) begin
            AST_FIXED_BITS: assert (rd_data[7:3] == {3'b000, SRC_FIXED}); // R4
        end
        if (rst_n && addr == ADDR_CLEAR) begin
            AST_CLEAR_READS_ZERO: assert (rd_data == 8'h00); // R10
        end
    end
endmodule

bind keyed_wdt keyed_wdt_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lclk      (lclk),
    .lrst_n    (lrst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .rst_req   (rst_req),
    .sel_q     (sel_q),
    .pend_q    (pend_q),
    .req_q     (req_q),
    .ack_s     (ack_s),
    .ovf_l     (ovf_l),
    .lcnt      (lcnt),
    .lcnt_last (lcnt_last)
);

// File: tb/keyed_wdt_test.sv
// Directed bench for keyed_wdt: one task per scenario, each checking itself.
`timescale 1ns/1ps
module keyed_wdt_test;
    localparam int BE    = 2;   // small base exponent keeps runs short
    localparam int RATIO = 10;  // bus cycles per slow cycle

    logic       clk = 1'b0;
    logic       lclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_data;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;     // 50 MHz
    always #100 lclk = ~lclk;  // slow clock

    keyed_wdt #(.SEL_W(3), .BASE_EXP(BE)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .lclk    (lclk),
        .lrst_n  (lrst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    // Bus cycles until rst_req is seen high at a falling edge.
    task automatic wait_rst(input int limit, output int k);
        k = 0;
        while (k <= limit) begin
            @(negedge clk);
            k++;
            if (rst_req) break;
        end
    endtask

    function automatic int per(input int n);
        return (1 << (BE + n)) * RATIO;
    endfunction

    task automatic t_reset;
        logic [7:0] d;
        int k;
        bus_read(1'b0, d);
        chk_eq("R1 mode reads 0x1F after reset", d, 8'h1F);
        chk_eq("R1 rst_req low after reset", rst_req, 0);
        bus_read(1'b1, d);
        chk_eq("R10 restart register reads zero", d, 8'h00);
        wait_rst(per(7) + 60, k);
        chk_rng("R2 default timeout from reset", k, per(7) - 15, per(7) + 30);
        @(negedge clk);
        chk_eq("R8 pulse is one cycle", rst_req, 0);
        bus_read(1'b0, d);
        chk_eq("R9 selector back to max", d, 8'h1F);
    endtask

    task automatic t_fixed_bits;
        logic [7:0] d;
        repeat (80) @(negedge clk);
        bus_write(1'b0, 8'h00);
        bus_read(1'b0, d);
        chk_eq("R4 source bits fixed on zero write", d, 8'h18);
        bus_write(1'b0, 8'hE5);
        bus_read(1'b0, d);
        chk_eq("R4 upper bits ignored", d, 8'h1D);
    endtask

    task automatic t_period(input int n);
        int k;
        repeat (80) @(negedge clk);
        bus_write(1'b0, 8'hF8 | 8'(n));
        wait_rst(per(n) + 80, k);
        chk_rng($sformatf("R3 R11 timeout for selector %0d", n), k, per(n) + 12, per(n) + 48);
    endtask

    task automatic t_refresh(input logic use_key);
        int k;
        int seen = 0;
        repeat (80) @(negedge clk);
        bus_write(1'b0, 8'h01);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 50; j++) begin
                @(negedge clk);
                if (rst_req) seen++;
            end
            if (use_key) bus_write(1'b1, 8'hAC);
            else         bus_write(1'b0, 8'h01);
        end
        if (use_key) begin
            chk_eq("R5 key writes hold off reset", seen, 0);
            wait_rst(per(1) + 80, k);
            chk_rng("R5 timeout restarts at key write", k, per(1) + 12, per(1) + 48);
        end else begin
            chk_eq("R6 mode writes hold off reset", seen, 0);
            wait_rst(per(1) + 80, k);
            chk_rng("R6 timeout restarts at mode write", k, per(1) + 12, per(1) + 48);
        end
    endtask

    task automatic t_bad_key;
        logic [7:0] d;
        int k;
        repeat (80) @(negedge clk);
        bus_write(1'b0, 8'h03);
        repeat (80) @(negedge clk);
        chk_eq("R7 rst_req low before bad key", rst_req, 0);
        bus_write(1'b1, 8'h5A);
        chk_eq("R7 bad key raises rst_req next cycle", rst_req, 1);
        @(negedge clk);
        chk_eq("R8 bad key pulse is one cycle", rst_req, 0);
        bus_read(1'b0, d);
        chk_eq("R9 selector max after bad key", d, 8'h1F);
        wait_rst(per(7) + 80, k);
        chk_rng("R9 max timeout after reset request", k, per(7) + 8, per(7) + 48);
    endtask

    initial begin
        repeat (30) @(negedge clk);
        rst_n  = 1'b1;
        lrst_n = 1'b1;
        t_reset();
        t_fixed_bits();
        t_period(0);
        t_period(1);
        t_period(3);
        t_refresh(1'b1);
        t_refresh(1'b0);
        t_bad_key();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule